// File: doc/BRIEF.md
# Private Cache Line Coherence Controller

This block holds the coherence state of a few lines in one core's private write-back, write-allocate cache that takes part in a directory-based protocol. The processor side presents one load or store per cycle to a line index. Loads and stores that already have the right permission complete at once and send no message. A request without permission sends a sharing or ownership request to the directory, moves the line to a transient waiting state, and stalls the processor until the line is usable. The processor keeps its request raised and retries until it completes.

On the network side the block accepts one incoming message per cycle: data grants from the directory, and directory demands to give up or write back a line. It answers each demand in the same cycle on a single outgoing message port. Every outgoing message carries this cache's site number. Line data is reduced to a version value: a store writes the value and a writeback returns it.

An incoming message always has the outgoing port and the line storage in its cycle. Any processor request in that cycle is stalled and must be retried.

Top module: `coh_line_ctrl`

## Requirements
- R1: While reset is asserted and right after it, no message is sent and no request completes; every line starts not resident (a first load of any line sends a sharing request).
- R2: A load to a non-resident line sends a sharing request (code 0) for that line, stalls the processor and makes the line waiting.
- R3: A store to a non-resident line or to a shared line sends an ownership request (code 1), stalls the processor and makes the line waiting; the store does not complete before ownership is granted.
- R4: For a waiting line, a sharing grant (code 6) installs its data and makes the line shared; an ownership grant (code 7) installs its data and makes the line exclusive.
- R5: A load to a shared or exclusive line completes in the same cycle, returns the line's version and sends no message.
- R6: A store to an exclusive line completes in the same cycle, sends no message and replaces the line's version with the store data.
- R7: While a line is waiting, loads and stores to it are stalled and send no message.
- R8: An invalidation demand (code 3) to a shared line is answered with an invalidation ack (code 5) and the line becomes non-resident; to an exclusive line it is answered with a writeback (code 4) carrying the version, and the line becomes non-resident.
- R9: A writeback demand (code 2) to an exclusive line is answered with a writeback (code 4) carrying the version, and the line becomes shared.
- R10: A writeback demand to a line that is not exclusive, and a grant to a line that is not waiting, send nothing and leave the line unchanged.
- R11: When an incoming message is present, a processor request in the same cycle is stalled, whichever line either one names.
- R12: Every outgoing message carries the SITE_ID parameter as its site field, the line index it concerns, and data zero except for writebacks.
- R13: An invalidation demand to a line that is non-resident or waiting is answered with an invalidation ack and the line state is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request valid |
| cpu_wr | input | 1 | 1 for store, 0 for load |
| cpu_line | input | IDX_W | Line index of the request |
| cpu_wdata | input | VER_W | Version written by a store |
| cpu_hit | output | 1 | Request completes this cycle |
| cpu_stall | output | 1 | Request not completed, retry |
| cpu_rdata | output | VER_W | Line version on a completing request |
| in_vld | input | 1 | Incoming message valid |
| in_kind | input | 3 | Incoming message code |
| in_line | input | IDX_W | Line index of incoming message |
| in_data | input | VER_W | Data of a grant |
| out_vld | output | 1 | Outgoing message valid |
| out_kind | output | 3 | Outgoing message code |
| out_line | output | IDX_W | Line index of outgoing message |
| out_site | output | SITE_W | Site number of this cache |
| out_data | output | VER_W | Data of a writeback |

## Verification
A wrong line state shows at the ports no later than the next processor request or directory demand to that line. A line wrongly left waiting stalls a load that should complete. A line wrongly left shared sends an ownership request instead of completing a store. A lost exclusive state answers a writeback demand with silence instead of data. The bench drives each state through every input that leaves it and reads the state back through the next request, so a bad transition is seen within one or two cycles of the cause.

// File: rtl/coh_pkg.sv
package coh_pkg;

   typedef enum logic [1:0] {
      LS_NONE = 2'd0,
      LS_SHRD = 2'd1,
      LS_EXCL = 2'd2,
      LS_PEND = 2'd3
   } line_st_t;

   localparam int ST_W = 2;

   typedef enum logic [2:0] {
      M_SH_REQ  = 3'd0,
      M_EX_REQ  = 3'd1,
      M_WB_REQ  = 3'd2,
      M_INV_REQ = 3'd3,
      M_WB_RSP  = 3'd4,
      M_INV_RSP = 3'd5,
      M_SH_RSP  = 3'd6,
      M_EX_RSP  = 3'd7
   } msg_t;

   localparam int MSG_W = 3;

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
   import coh_pkg::*;
#(
   parameter int NUM_LINES = 4,
   parameter int VER_W     = 8,
   localparam int IDX_W    = $clog2(NUM_LINES)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [IDX_W-1:0]           wr_idx,
   input  line_st_t                   wr_st,
   input  logic [VER_W-1:0]           wr_ver,
   output logic [NUM_LINES*ST_W-1:0]  st_flat,
   output logic [NUM_LINES*VER_W-1:0] ver_flat
);

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      line_st_t         st_q;
      logic [VER_W-1:0] ver_q;
      logic             sel;

      assign sel = wr_en && (wr_idx == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q  <= LS_NONE;
            ver_q <= '0;
         end else if (sel) begin
            st_q  <= wr_st;
            ver_q <= wr_ver;
         end
      end

      assign st_flat[g*ST_W +: ST_W]    = st_q;
      assign ver_flat[g*VER_W +: VER_W] = ver_q;
   end

endmodule

// File: rtl/coh_decide.sv
module coh_decide
   import coh_pkg::*;
#(
   parameter int VER_W = 8
) (
   input  logic             cpu_act,
   input  logic             cpu_store,
   input  logic [VER_W-1:0] cpu_wdata,
   input  logic             msg_act,
   input  msg_t             msg_kind,
   input  logic [VER_W-1:0] msg_data,
   input  line_st_t         cur_st,
   input  logic [VER_W-1:0] cur_ver,
   output logic             upd,
   output line_st_t         nxt_st,
   output logic [VER_W-1:0] nxt_ver,
   output logic             snd,
   output msg_t             snd_kind,
   output logic [VER_W-1:0] snd_data,
   output logic             hit,
   output logic             stall
);

   always_comb begin
      upd      = 1'b0;
      nxt_st   = cur_st;
      nxt_ver  = cur_ver;
      snd      = 1'b0;
      snd_kind = M_SH_REQ;
      snd_data = '0;
      hit      = 1'b0;
      stall    = 1'b0;
      if (msg_act) begin
         stall = cpu_act;
         unique case (msg_kind)
            M_SH_RSP, M_EX_RSP: begin
               if (cur_st == LS_PEND) begin
                  upd     = 1'b1;
                  nxt_st  = (msg_kind == M_EX_RSP) ? LS_EXCL : LS_SHRD;
                  nxt_ver = msg_data;
               end
            end
            M_INV_REQ: begin
               snd = 1'b1;
               if (cur_st == LS_EXCL) begin
                  snd_kind = M_WB_RSP;
                  snd_data = cur_ver;
               end else begin
                  snd_kind = M_INV_RSP;
               end
               if (cur_st == LS_EXCL || cur_st == LS_SHRD) begin
                  upd    = 1'b1;
                  nxt_st = LS_NONE;
               end
            end
            M_WB_REQ: begin
               if (cur_st == LS_EXCL) begin
                  snd      = 1'b1;
                  snd_kind = M_WB_RSP;
                  snd_data = cur_ver;
                  upd      = 1'b1;
                  nxt_st   = LS_SHRD;
               end
            end
            default: ;
         endcase
      end else if (cpu_act) begin
         unique case (cur_st)
            LS_NONE: begin
               snd      = 1'b1;
               snd_kind = cpu_store ? M_EX_REQ : M_SH_REQ;
               upd      = 1'b1;
               nxt_st   = LS_PEND;
               stall    = 1'b1;
            end
            LS_SHRD: begin
               if (cpu_store) begin
                  snd      = 1'b1;
                  snd_kind = M_EX_REQ;
                  upd      = 1'b1;
                  nxt_st   = LS_PEND;
                  stall    = 1'b1;
               end else begin
                  hit = 1'b1;
               end
            end
            LS_EXCL: begin
               hit = 1'b1;
               if (cpu_store) begin
                  upd     = 1'b1;
                  nxt_ver = cpu_wdata;
               end
            end
            default: stall = 1'b1;
         endcase
      end
   end

endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
   import coh_pkg::*;
#(
   parameter int NUM_LINES = 4,
   parameter int VER_W     = 8,
   parameter int SITE_W    = 4,
   parameter int SITE_ID   = 0,
   localparam int IDX_W    = $clog2(NUM_LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_wr,
   input  logic [IDX_W-1:0]  cpu_line,
   input  logic [VER_W-1:0]  cpu_wdata,
   output logic              cpu_hit,
   output logic              cpu_stall,
   output logic [VER_W-1:0]  cpu_rdata,
   input  logic              in_vld,
   input  logic [MSG_W-1:0]  in_kind,
   input  logic [IDX_W-1:0]  in_line,
   input  logic [VER_W-1:0]  in_data,
   output logic              out_vld,
   output logic [MSG_W-1:0]  out_kind,
   output logic [IDX_W-1:0]  out_line,
   output logic [SITE_W-1:0] out_site,
   output logic [VER_W-1:0]  out_data
);

   if (NUM_LINES < 2) begin : g_bad_lines
      $error("coh_line_ctrl: NUM_LINES must be at least 2");
   end
   if (VER_W < 1) begin : g_bad_ver
      $error("coh_line_ctrl: VER_W must be positive");
   end
   if (SITE_ID < 0 || SITE_ID >= (1 << SITE_W)) begin : g_bad_site
      $error("coh_line_ctrl: SITE_ID does not fit in SITE_W bits");
   end

   localparam logic [SITE_W-1:0] SITE_V = SITE_W'(SITE_ID);

   logic                       cpu_act, msg_act;
   logic [IDX_W-1:0]           sel_idx;
   logic [NUM_LINES*ST_W-1:0]  st_flat;
   logic [NUM_LINES*VER_W-1:0] ver_flat;
   line_st_t                   cur_st, nxt_st;
   logic [VER_W-1:0]           cur_ver, nxt_ver, snd_data;
   logic                       upd, snd, hit, stall;
   msg_t                       snd_kind;

   assign cpu_act = cpu_req && rst_n;
   assign msg_act = in_vld && rst_n;
   assign sel_idx = msg_act ? in_line : cpu_line;
   assign cur_st  = line_st_t'(st_flat[sel_idx*ST_W +: ST_W]);
   assign cur_ver = ver_flat[sel_idx*VER_W +: VER_W];

   coh_line_store #(
      .NUM_LINES (NUM_LINES),
      .VER_W     (VER_W)
   ) i_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (upd),
      .wr_idx   (sel_idx),
      .wr_st    (nxt_st),
      .wr_ver   (nxt_ver),
      .st_flat  (st_flat),
      .ver_flat (ver_flat)
   );

   coh_decide #(
      .VER_W (VER_W)
   ) i_decide (
      .cpu_act   (cpu_act),
      .cpu_store (cpu_wr),
      .cpu_wdata (cpu_wdata),
      .msg_act   (msg_act),
      .msg_kind  (msg_t'(in_kind)),
      .msg_data  (in_data),
      .cur_st    (cur_st),
      .cur_ver   (cur_ver),
      .upd       (upd),
      .nxt_st    (nxt_st),
      .nxt_ver   (nxt_ver),
      .snd       (snd),
      .snd_kind  (snd_kind),
      .snd_data  (snd_data),
      .hit       (hit),
      .stall     (stall)
   );

   assign cpu_hit   = hit;
   assign cpu_stall = stall;
   assign cpu_rdata = hit ? cur_ver : '0;
   assign out_vld   = snd;
   assign out_kind  = snd_kind;
   assign out_line  = sel_idx;
   assign out_site  = SITE_V;
   assign out_data  = snd_data;

endmodule

// File: rtl/coh_line_ctrl_chk.sv
module coh_line_ctrl_chk
   import coh_pkg::*;
#(
   parameter int NUM_LINES = 4,
   localparam int IDX_W    = $clog2(NUM_LINES)
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      cpu_req,
   input logic                      cpu_wr,
   input logic [IDX_W-1:0]          cpu_line,
   input logic                      cpu_hit,
   input logic                      cpu_stall,
   input logic                      in_vld,
   input logic [MSG_W-1:0]          in_kind,
   input logic [IDX_W-1:0]          in_line,
   input logic                      out_vld,
   input logic [MSG_W-1:0]          out_kind,
   input logic [NUM_LINES*ST_W-1:0] st_flat
);

   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |-> (!out_vld && !cpu_hit));

   p_load_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !cpu_wr && !in_vld && st_flat[cpu_line*ST_W +: ST_W] == LS_NONE)
      |=> st_flat[$past(cpu_line)*ST_W +: ST_W] == LS_PEND);

   p_store_perm_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_wr && !in_vld && st_flat[cpu_line*ST_W +: ST_W] == LS_SHRD)
      |-> (out_vld && out_kind == M_EX_REQ && !cpu_hit));

   p_hit_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_hit |-> (!out_vld && !cpu_stall));

   p_pend_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !in_vld && st_flat[cpu_line*ST_W +: ST_W] == LS_PEND)
      |-> (cpu_stall && !cpu_hit && !out_vld));

   p_inv_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_kind == M_INV_REQ && st_flat[in_line*ST_W +: ST_W] == LS_SHRD)
      |-> (out_vld && out_kind == M_INV_RSP));

   p_wb_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_kind == M_WB_REQ && st_flat[in_line*ST_W +: ST_W] == LS_EXCL)
      |=> st_flat[$past(in_line)*ST_W +: ST_W] == LS_SHRD);

   p_stray_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && (in_kind == M_SH_RSP || in_kind == M_EX_RSP)
       && st_flat[in_line*ST_W +: ST_W] != LS_PEND)
      |=> (st_flat[$past(in_line)*ST_W +: ST_W] == $past(st_flat[in_line*ST_W +: ST_W])));

   p_msg_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |-> !cpu_hit);

endmodule

bind coh_line_ctrl coh_line_ctrl_chk #(
   .NUM_LINES (NUM_LINES)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_req   (cpu_req),
   .cpu_wr    (cpu_wr),
   .cpu_line  (cpu_line),
   .cpu_hit   (cpu_hit),
   .cpu_stall (cpu_stall),
   .in_vld    (in_vld),
   .in_kind   (in_kind),
   .in_line   (in_line),
   .out_vld   (out_vld),
   .out_kind  (out_kind),
   .st_flat   (st_flat)
);

// File: tb/test_coh_line_ctrl.sv
module test_coh_line_ctrl;

   localparam int NL   = 4;
   localparam int VW   = 8;
   localparam int SW   = 4;
   localparam int SID  = 5;
   localparam int IW   = $clog2(NL);

   localparam logic [2:0] K_SHQ = 3'd0, K_EXQ = 3'd1, K_WBQ = 3'd2, K_INQ = 3'd3,
                          K_WBP = 3'd4, K_INP = 3'd5, K_SHP = 3'd6, K_EXP = 3'd7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req = 1'b0, cpu_wr = 1'b0;
   logic [IW-1:0] cpu_line = '0;
   logic [VW-1:0] cpu_wdata = '0;
   logic          cpu_hit, cpu_stall;
   logic [VW-1:0] cpu_rdata;
   logic          in_vld = 1'b0;
   logic [2:0]    in_kind = '0;
   logic [IW-1:0] in_line = '0;
   logic [VW-1:0] in_data = '0;
   logic          out_vld;
   logic [2:0]    out_kind;
   logic [IW-1:0] out_line;
   logic [SW-1:0] out_site;
   logic [VW-1:0] out_data;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [2:0]    q_kind[$];
   logic [IW-1:0] q_line[$];
   logic [VW-1:0] q_data[$];
   string         q_tag[$];

   always #10 clk = ~clk;

   coh_line_ctrl #(
      .NUM_LINES (NL),
      .VER_W     (VW),
      .SITE_W    (SW),
      .SITE_ID   (SID)
   ) i_coh_line_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_req   (cpu_req),
      .cpu_wr    (cpu_wr),
      .cpu_line  (cpu_line),
      .cpu_wdata (cpu_wdata),
      .cpu_hit   (cpu_hit),
      .cpu_stall (cpu_stall),
      .cpu_rdata (cpu_rdata),
      .in_vld    (in_vld),
      .in_kind   (in_kind),
      .in_line   (in_line),
      .in_data   (in_data),
      .out_vld   (out_vld),
      .out_kind  (out_kind),
      .out_line  (out_line),
      .out_site  (out_site),
      .out_data  (out_data)
   );

   // Monitor: every outgoing message is matched against the scoreboard queue.
   always @(negedge clk) begin
      if (rst_n && out_vld) begin
         n_chk++;
         if (q_kind.size() == 0) begin
            n_fail++;
            $display("FAIL unexpected message: actual kind=%0d line=%0d data=%0h, expected none",
                     out_kind, out_line, out_data);
         end else begin
            logic [2:0]    ek;
            logic [IW-1:0] el;
            logic [VW-1:0] ed;
            string         et;
            ek = q_kind.pop_front();
            el = q_line.pop_front();
            ed = q_data.pop_front();
            et = q_tag.pop_front();
            if (out_kind !== ek || out_line !== el || out_data !== ed) begin
               n_fail++;
               $display("FAIL %s message: actual kind=%0d line=%0d data=%0h, expected kind=%0d line=%0d data=%0h",
                        et, out_kind, out_line, out_data, ek, el, ed);
            end
            if (out_site !== SW'(SID)) begin
               n_fail++;
               $display("FAIL R12 site field: actual %0d, expected %0d", out_site, SID);
            end
         end
      end
   end

   task automatic act(input bit cr, input bit cw, input int cl, input int cd,
                      input bit iv, input logic [2:0] ik, input int il, input int id);
      @(posedge clk);
      #2;
      cpu_req   = cr;
      cpu_wr    = cw;
      cpu_line  = IW'(cl);
      cpu_wdata = VW'(cd);
      in_vld    = iv;
      in_kind   = ik;
      in_line   = IW'(il);
      in_data   = VW'(id);
   endtask

   task automatic expect_msg(input logic [2:0] k, input int l, input int d, input string tag);
      q_kind.push_back(k);
      q_line.push_back(IW'(l));
      q_data.push_back(VW'(d));
      q_tag.push_back(tag);
   endtask

   task automatic tick(input string tag, input bit e_hit, input bit e_stall, input int e_rd);
      @(negedge clk);
      n_chk++;
      if (cpu_hit !== e_hit || cpu_stall !== e_stall ||
          (e_hit && cpu_rdata !== VW'(e_rd))) begin
         n_fail++;
         $display("FAIL %s processor port: actual hit=%0b stall=%0b rdata=%0h, expected hit=%0b stall=%0b rdata=%0h",
                  tag, cpu_hit, cpu_stall, cpu_rdata, e_hit, e_stall, VW'(e_rd));
      end
   endtask

   task automatic idle();
      act(0, 0, 0, 0, 0, K_SHQ, 0, 0);
   endtask

   initial begin
      #(20 * 5000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual run still busy, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: quiet during reset even with requests presented
      cpu_req = 1'b1;
      in_vld  = 1'b1;
      in_kind = K_INQ;
      repeat (3) begin
         @(negedge clk);
         n_chk++;
         if (out_vld !== 1'b0 || cpu_hit !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset: actual out_vld=%0b hit=%0b, expected 0 0", out_vld, cpu_hit);
         end
      end
      @(posedge clk);
      #2;
      rst_n   = 1'b1;
      cpu_req = 1'b0;
      in_vld  = 1'b0;

      // R1 R2: first load of line 0 misses
      act(1, 0, 0, 0, 0, K_SHQ, 0, 0);
      expect_msg(K_SHQ, 0, 0, "R2");
      tick("R2", 0, 1, 0);
      // R7: waiting line stalls loads and stores
      act(1, 0, 0, 0, 0, K_SHQ, 0, 0);
      tick("R7", 0, 1, 0);
      act(1, 1, 0, 9, 0, K_SHQ, 0, 0);
      tick("R7", 0, 1, 0);
      // R4: sharing grant
      act(0, 0, 0, 0, 1, K_SHP, 0, 'h11);
      tick("R4", 0, 0, 0);
      // R5: load hit in shared
      act(1, 0, 0, 0, 0, K_SHQ, 0, 0);
      tick("R5", 1, 0, 'h11);
      // R3: store to shared needs ownership
      act(1, 1, 0, 'h22, 0, K_SHQ, 0, 0);
      expect_msg(K_EXQ, 0, 0, "R3");
      tick("R3", 0, 1, 0);
      // R4: ownership grant
      act(0, 0, 0, 0, 1, K_EXP, 0, 'h33);
      tick("R4", 0, 0, 0);
      act(1, 0, 0, 0, 0, K_SHQ, 0, 0);
      tick("R4", 1, 0, 'h33);
      // R6: store hit in exclusive
      act(1, 1, 0, 'h44, 0, K_SHQ, 0, 0);
      tick("R6", 1, 0, 'h33);
      act(1, 0, 0, 0, 0, K_SHQ, 0, 0);
      tick("R6", 1, 0, 'h44);
      // R9: writeback demand to exclusive
      act(0, 0, 0, 0, 1, K_WBQ, 0, 0);
      expect_msg(K_WBP, 0, 'h44, "R9");
      tick("R9", 0, 0, 0);
      act(1, 1, 0, 'h45, 0, K_SHQ, 0, 0);
      expect_msg(K_EXQ, 0, 0, "R9");
      tick("R9", 0, 1, 0);
      act(0, 0, 0, 0, 1, K_SHP, 0, 'h46);
      tick("R4", 0, 0, 0);
      act(1, 0, 0, 0, 0, K_SHQ, 0, 0);
      tick("R9", 1, 0, 'h46);
      // R10: writeback demand to shared ignored
      act(0, 0, 0, 0, 1, K_WBQ, 0, 0);
      tick("R10", 0, 0, 0);
      act(1, 0, 0, 0, 0, K_SHQ, 0, 0);
      tick("R10", 1, 0, 'h46);
      // R8: invalidation of shared
      act(0, 0, 0, 0, 1, K_INQ, 0, 0);
      expect_msg(K_INP, 0, 0, "R8");
      tick("R8", 0, 0, 0);
      act(1, 0, 0, 0, 0, K_SHQ, 0, 0);
      expect_msg(K_SHQ, 0, 0, "R8");
      tick("R8", 0, 1, 0);
      // R10: writeback demand to waiting ignored; then ownership grant
      act(0, 0, 0, 0, 1, K_WBQ, 0, 0);
      tick("R10", 0, 0, 0);
      act(0, 0, 0, 0, 1, K_EXP, 0, 'h55);
      tick("R4", 0, 0, 0);
      // R8: invalidation of exclusive writes back
      act(0, 0, 0, 0, 1, K_INQ, 0, 0);
      expect_msg(K_WBP, 0, 'h55, "R8");
      tick("R8", 0, 0, 0);
      act(1, 0, 0, 0, 0, K_SHQ, 0, 0);
      expect_msg(K_SHQ, 0, 0, "R8");
      tick("R8", 0, 1, 0);
      // R13: invalidation of waiting line acked, stays waiting
      act(0, 0, 0, 0, 1, K_INQ, 0, 0);
      expect_msg(K_INP, 0, 0, "R13");
      tick("R13", 0, 0, 0);
      act(1, 0, 0, 0, 0, K_SHQ, 0, 0);
      tick("R13", 0, 1, 0);
      // R13: invalidation of non-resident line acked, stays non-resident
      act(0, 0, 0, 0, 1, K_INQ, 3, 0);
      expect_msg(K_INP, 3, 0, "R13");
      tick("R13", 0, 0, 0);
      act(1, 0, 3, 0, 0, K_SHQ, 0, 0);
      expect_msg(K_SHQ, 3, 0, "R13");
      tick("R13", 0, 1, 0);
      // R10: stray grant to shared ignored
      act(0, 0, 0, 0, 1, K_SHP, 0, 'h66);
      tick("R4", 0, 0, 0);
      act(0, 0, 0, 0, 1, K_EXP, 0, 'h77);
      tick("R10", 0, 0, 0);
      act(1, 0, 0, 0, 0, K_SHQ, 0, 0);
      tick("R10", 1, 0, 'h66);
      // R3: store miss on line 1
      act(1, 1, 1, 'h12, 0, K_SHQ, 0, 0);
      expect_msg(K_EXQ, 1, 0, "R3");
      tick("R3", 0, 1, 0);
      act(0, 0, 0, 0, 1, K_EXP, 1, 'h80);
      tick("R4", 0, 0, 0);
      // R11: message and same-line load together
      act(1, 0, 1, 0, 1, K_WBQ, 1, 0);
      expect_msg(K_WBP, 1, 'h80, "R11");
      tick("R11", 0, 1, 0);
      act(1, 0, 1, 0, 0, K_SHQ, 0, 0);
      tick("R11", 1, 0, 'h80);
      // R11: message to other line still stalls a would-be hit
      act(1, 0, 0, 0, 1, K_SHP, 2, 'h99);
      tick("R11", 0, 1, 0);
      act(1, 0, 0, 0, 0, K_SHQ, 0, 0);
      tick("R11", 1, 0, 'h66);
      // R10: the stray grant left line 2 non-resident
      act(1, 0, 2, 0, 0, K_SHQ, 0, 0);
      expect_msg(K_SHQ, 2, 0, "R10");
      tick("R10", 0, 1, 0);
      idle();
      tick("R12", 0, 0, 0);

      n_chk++;
      if (q_kind.size() != 0) begin
         n_fail++;
         $display("FAIL R12 missing messages: actual %0d outstanding, expected 0", q_kind.size());
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule